// File: doc/BRIEF.md
# DMA Channel Request Gating

This block sits inside one DMA channel, between the peripheral handshake lines and the bus master state machine. Each cycle it decides whether a pending source request or destination request may be served. It first converts each handshake input to active-high, using a per-side polarity bit. It then checks the channel FIFO fill level against one of two readiness rules. When the destination peripheral controls the flow, it can hold source servicing back until the destination has asked for data. The two grants are registered.

Alongside the grants, the block forms three values for the bus master:

- the burst length to issue, capped by a programmable maximum;
- the four protection attribute bits;
- the bus lock output.

The bus master, the address generator, the FIFO storage and the register file sit outside the block. The testbench models them.

Top module: `dma_req_gate`

## Requirements
- R1: A handshake input counts as asserted when it differs from its polarity bit. Polarity 0 means active high and polarity 1 means active low. This applies separately to the source side (`src_req_in`, `cfg_src_pol`) and the destination side (`dst_req_in`, `cfg_dst_pol`).
- R2: With `cfg_half_mode` = 0, a source request is ready when the free space (`FIFO_BYTES` − `fifo_fill`) is at least `xfer_bytes`. A destination request is ready when `fifo_fill` is at least `xfer_bytes`.
- R3: With `cfg_half_mode` = 1 and neither `burst_last` nor `block_last` high, a destination request is ready only when `fifo_fill` ≥ `FIFO_BYTES`/2.
- R4: With `cfg_half_mode` = 1 and neither `burst_last` nor `block_last` high, a source request is ready only when the free space is strictly greater than `FIFO_BYTES`/2.
- R5: With `cfg_half_mode` = 1 and either `burst_last` or `block_last` high, the rule of R2 applies instead of the half-depth rule.
- R6: When `cfg_src_hold` = 1 and `dst_is_fc` = 1, a source request is granted only if a destination request is present in the same cycle, or has been seen since the last `block_last` or channel disable. A `block_last` clears that memory, and the clear takes effect from the next cycle.
- R7: When `cfg_src_hold` = 0 or `dst_is_fc` = 0, a ready source request is granted without waiting for any destination request.
- R8: `burst_len` equals `req_burst_len` when `cfg_max_burst` is 0. Otherwise it equals the smaller of `req_burst_len` and `cfg_max_burst`. Both length fields are 10 bits wide.
- R9: `hprot[3:1]` equals `cfg_prot` bit for bit, and `hprot[0]` is always 1.
- R10: `bus_lock` is high exactly when both `cfg_lock` and `lock_want` are high.
- R11: `src_grant` and `dst_grant` are registered. They reflect the inputs sampled at the previous rising edge. Both are 0 while `rst_n` is low, and in the cycle after `ch_en` was sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ch_en | input | 1 | Channel enable; low clears grants and the destination-seen memory |
| src_req_in | input | 1 | Raw source handshake request |
| dst_req_in | input | 1 | Raw destination handshake request |
| cfg_src_pol | input | 1 | Source handshake polarity (1 = active low) |
| cfg_dst_pol | input | 1 | Destination handshake polarity (1 = active low) |
| cfg_half_mode | input | 1 | FIFO readiness rule: 0 single transfer, 1 half depth |
| cfg_src_hold | input | 1 | Hold source servicing until a destination request |
| dst_is_fc | input | 1 | Destination peripheral is the flow controller |
| fifo_fill | input | CNT_W | Bytes currently held in the FIFO |
| xfer_bytes | input | CNT_W | Bytes moved by one bus transfer |
| burst_last | input | 1 | Last transfers of the current burst request |
| block_last | input | 1 | End of the current block |
| req_burst_len | input | 10 | Burst length the master asks for |
| cfg_max_burst | input | 10 | Maximum burst length, 0 = unlimited |
| cfg_prot | input | 3 | Protection attribute field |
| cfg_lock | input | 1 | Bus lock enable |
| lock_want | input | 1 | Channel requests a locked period |
| src_grant | output | 1 | Registered source service grant |
| dst_grant | output | 1 | Registered destination service grant |
| burst_len | output | 10 | Capped burst length |
| hprot | output | 4 | Bus protection attributes |
| bus_lock | output | 1 | Bus lock to the master |

## Verification
The only internal state is the destination-seen memory and the two grant registers. A fault in any of them appears at a grant port one clock after the inputs that exposed it. A destination-seen flag that sticks high shows as a source grant in the cycle after a `block_last`, in place of the expected hold. A flag that never sets shows as a missing source grant once the destination pulse has passed. A wrong readiness threshold shows as a grant mismatch at exactly the fill level where the rule flips, so the sweeps cover every fill level from empty to full.

// File: rtl/dma_gate_pkg.sv
// Package: shared constants for the DMA request gating block.
// Assumes: burst lengths are 10 bits and protection is a 3-bit field.
package dma_gate_pkg;
    localparam int BLEN_W = 10;
    localparam int PROT_W = 3;

    typedef logic [BLEN_W-1:0] blen_t;
endpackage

// File: rtl/dma_hs_norm.sv
// Module: converts N raw handshake lines to active-high form.
// Assumes: pol bit 1 marks a line as active low.
module dma_hs_norm #(
    parameter int N = 2
) (
    input  logic [N-1:0] raw,
    input  logic [N-1:0] pol,
    output logic [N-1:0] act
);
    for (genvar i = 0; i < N; i++) begin : g_line
        // per-line polarity correction
        assign act[i] = raw[i] ^ pol[i];
    end
endmodule

// File: rtl/dma_fifo_ready.sv
// Module: decides whether the FIFO can accept (source) or supply
// (destination) data under the selected readiness rule.
// Assumes: fill never exceeds DEPTH; all counts are in bytes.
module dma_fifo_ready #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] fill,
    input  logic [CNT_W-1:0] xfer,
    input  logic             half_mode,
    input  logic             waive,
    output logic             src_ok,
    output logic             dst_ok
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(DEPTH / 2);

    logic [CNT_W-1:0] space;
    logic             use_half;

    // free bytes and active rule
    always_comb begin
        space    = FULL - fill;
        use_half = half_mode && !waive;
    end

    // readiness per side
    always_comb begin
        if (use_half) begin
            src_ok = space > HALF;
            dst_ok = fill >= HALF;
        end else begin
            src_ok = space >= xfer;
            dst_ok = fill >= xfer;
        end
    end
endmodule

// File: rtl/dma_burst_cap.sv
// Module: limits the requested burst length by a programmable maximum.
// Assumes: a maximum of zero means no limit.
module dma_burst_cap
    import dma_gate_pkg::*;
(
    input  blen_t req_len,
    input  blen_t max_len,
    output blen_t out_len
);
    // choose the smaller length unless unlimited
    always_comb begin
        if (max_len != '0 && req_len > max_len) out_len = max_len;
        else                                     out_len = req_len;
    end
endmodule

// File: rtl/dma_req_gate.sv
// Module: request gating for one DMA channel. Issues registered
// source/destination grants, capped burst length, protection bits
// and bus lock.
// Assumes: synchronous active-low reset; fifo_fill <= FIFO_BYTES.
module dma_req_gate
    import dma_gate_pkg::*;
#(
    parameter int FIFO_BYTES = 16,
    parameter int CNT_W      = $clog2(FIFO_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ch_en,
    input  logic              src_req_in,
    input  logic              dst_req_in,
    input  logic              cfg_src_pol,
    input  logic              cfg_dst_pol,
    input  logic              cfg_half_mode,
    input  logic              cfg_src_hold,
    input  logic              dst_is_fc,
    input  logic [CNT_W-1:0]  fifo_fill,
    input  logic [CNT_W-1:0]  xfer_bytes,
    input  logic              burst_last,
    input  logic              block_last,
    input  logic [BLEN_W-1:0] req_burst_len,
    input  logic [BLEN_W-1:0] cfg_max_burst,
    input  logic [PROT_W-1:0] cfg_prot,
    input  logic              cfg_lock,
    input  logic              lock_want,
    output logic              src_grant,
    output logic              dst_grant,
    output logic [BLEN_W-1:0] burst_len,
    output logic [3:0]        hprot,
    output logic              bus_lock
);
    logic [1:0] req_act;
    logic       src_req, dst_req;
    logic       src_ok, dst_ok;
    logic       dst_seen;
    logic       src_allowed;

    dma_hs_norm #(.N(2)) i_norm (
        .raw ({dst_req_in, src_req_in}),
        .pol ({cfg_dst_pol, cfg_src_pol}),
        .act (req_act)
    );

    assign src_req = req_act[0];
    assign dst_req = req_act[1];

    dma_fifo_ready #(.DEPTH(FIFO_BYTES), .CNT_W(CNT_W)) i_ready (
        .fill      (fifo_fill),
        .xfer      (xfer_bytes),
        .half_mode (cfg_half_mode),
        .waive     (burst_last | block_last),
        .src_ok    (src_ok),
        .dst_ok    (dst_ok)
    );

    dma_burst_cap i_cap (
        .req_len (req_burst_len),
        .max_len (cfg_max_burst),
        .out_len (burst_len)
    );

    // remember a destination request within the current block
    always_ff @(posedge clk) begin
        if (!rst_n || !ch_en || block_last) dst_seen <= 1'b0;
        else if (dst_req)                   dst_seen <= 1'b1;
    end

    // source hold-off when destination controls flow
    always_comb begin
        src_allowed = !(cfg_src_hold && dst_is_fc) || dst_seen || dst_req;
    end

    // registered service grants
    always_ff @(posedge clk) begin
        if (!rst_n || !ch_en) begin
            src_grant <= 1'b0;
            dst_grant <= 1'b0;
        end else begin
            src_grant <= src_req && src_ok && src_allowed;
            dst_grant <= dst_req && dst_ok;
        end
    end

    // bus attributes: data access bit forced high
    assign hprot    = {cfg_prot, 1'b1};
    assign bus_lock = cfg_lock & lock_want;
endmodule

// File: rtl/dma_req_gate_chk.sv
// Checker: temporal properties of dma_req_gate, bound to every instance.
// Assumes: same parameters as the gated block.
module dma_req_gate_chk #(
    parameter int FIFO_BYTES = 16,
    parameter int CNT_W      = $clog2(FIFO_BYTES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ch_en,
    input logic             src_req_in,
    input logic             dst_req_in,
    input logic             cfg_src_pol,
    input logic             cfg_dst_pol,
    input logic             cfg_half_mode,
    input logic [CNT_W-1:0] fifo_fill,
    input logic [CNT_W-1:0] xfer_bytes,
    input logic             burst_last,
    input logic             block_last,
    input logic [9:0]       req_burst_len,
    input logic [9:0]       cfg_max_burst,
    input logic             src_grant,
    input logic             dst_grant,
    input logic [9:0]       burst_len,
    input logic [3:0]       hprot
);
    // R11: a disabled channel yields no grant on the next cycle
    p_idle_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en |=> (!src_grant && !dst_grant));

    // R1: a source grant follows an asserted, polarity-corrected request
    p_src_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        src_grant |-> $past(src_req_in ^ cfg_src_pol));

    // R1: same for the destination side
    p_dst_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dst_grant |-> $past(dst_req_in ^ cfg_dst_pol));

    // R3: under the half rule the destination needs half a FIFO of data
    p_dst_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_grant && $past(cfg_half_mode && !burst_last && !block_last))
        |-> (int'($past(fifo_fill)) >= FIFO_BYTES / 2));

    // R4: under the half rule the source needs more than half free
    p_src_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_grant && $past(cfg_half_mode && !burst_last && !block_last))
        |-> ((FIFO_BYTES - int'($past(fifo_fill))) > FIFO_BYTES / 2));

    // R2: a destination grant never outruns the data present
    p_dst_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_grant && $past(!cfg_half_mode))
        |-> ($past(fifo_fill) >= $past(xfer_bytes)));

    // R8: a nonzero maximum is never exceeded
    p_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_max_burst != 10'd0) |-> (burst_len <= cfg_max_burst));

    // R8: the issued length never exceeds the request
    p_cap_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        burst_len <= req_burst_len);

    // R9: the data-access attribute bit is always set
    p_prot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hprot[0]);
endmodule

bind dma_req_gate dma_req_gate_chk #(.FIFO_BYTES(FIFO_BYTES), .CNT_W(CNT_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ch_en         (ch_en),
    .src_req_in    (src_req_in),
    .dst_req_in    (dst_req_in),
    .cfg_src_pol   (cfg_src_pol),
    .cfg_dst_pol   (cfg_dst_pol),
    .cfg_half_mode (cfg_half_mode),
    .fifo_fill     (fifo_fill),
    .xfer_bytes    (xfer_bytes),
    .burst_last    (burst_last),
    .block_last    (block_last),
    .req_burst_len (req_burst_len),
    .cfg_max_burst (cfg_max_burst),
    .src_grant     (src_grant),
    .dst_grant     (dst_grant),
    .burst_len     (burst_len),
    .hprot         (hprot)
);

// File: tb/test_dma_req_gate.sv
// Bench: near-exhaustive sweeps over a 16-byte FIFO configuration.
module test_dma_req_gate;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n, ch_en, src_req_in, dst_req_in, cfg_src_pol, cfg_dst_pol;
    logic          cfg_half_mode, cfg_src_hold, dst_is_fc, burst_last, block_last;
    logic [CW-1:0] fifo_fill, xfer_bytes;
    logic [9:0]    req_burst_len, cfg_max_burst, burst_len;
    logic [2:0]    cfg_prot;
    logic          cfg_lock, lock_want, src_grant, dst_grant, bus_lock;
    logic [3:0]    hprot;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    dma_req_gate #(.FIFO_BYTES(DEPTH)) i_dma_req_gate (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en),
        .src_req_in(src_req_in), .dst_req_in(dst_req_in),
        .cfg_src_pol(cfg_src_pol), .cfg_dst_pol(cfg_dst_pol),
        .cfg_half_mode(cfg_half_mode), .cfg_src_hold(cfg_src_hold),
        .dst_is_fc(dst_is_fc), .fifo_fill(fifo_fill), .xfer_bytes(xfer_bytes),
        .burst_last(burst_last), .block_last(block_last),
        .req_burst_len(req_burst_len), .cfg_max_burst(cfg_max_burst),
        .cfg_prot(cfg_prot), .cfg_lock(cfg_lock), .lock_want(lock_want),
        .src_grant(src_grant), .dst_grant(dst_grant), .burst_len(burst_len),
        .hprot(hprot), .bus_lock(bus_lock)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one clock: inputs already set at negedge, sample at next negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; ch_en = 1; src_req_in = 1; dst_req_in = 1;
        cfg_src_pol = 0; cfg_dst_pol = 0; cfg_half_mode = 0; cfg_src_hold = 0;
        dst_is_fc = 0; fifo_fill = 8; xfer_bytes = 1; burst_last = 0; block_last = 0;
        req_burst_len = 0; cfg_max_burst = 0; cfg_prot = 3'b001; cfg_lock = 0; lock_want = 0;
        @(negedge clk);
        step();
        // R11: reset holds grants low even with ready requests
        check("R11 src in reset", src_grant, 0);
        check("R11 dst in reset", dst_grant, 0);
        rst_n = 1;
        step();
        check("R11 src after reset", src_grant, 1);
        ch_en = 0;
        step();
        check("R11 src disabled", src_grant, 0);
        check("R11 dst disabled", dst_grant, 0);
        ch_en = 1;

        // R1..R5 sweep: rule, fill, width, waivers, polarities, requests
        for (int m = 0; m < 2; m++)
          for (int f = 0; f <= DEPTH; f++)
            for (int xi = 0; xi < 3; xi++)
              for (int w = 0; w < 4; w++)
                for (int p = 0; p < 4; p++)
                  for (int r = 0; r < 4; r++) begin
                      int x, sp;
                      bit s_on, d_on, s_ok, d_ok, waive;
                      string tag_s, tag_d;
                      x = 1 << xi;
                      cfg_half_mode = m[0]; fifo_fill = CW'(f); xfer_bytes = CW'(x);
                      burst_last = w[0]; block_last = w[1];
                      cfg_src_pol = p[0]; cfg_dst_pol = p[1];
                      src_req_in = r[0]; dst_req_in = r[1];
                      s_on = r[0] ^ p[0];  // R1 polarity
                      d_on = r[1] ^ p[1];
                      sp = DEPTH - f;
                      waive = (w != 0);
                      if (m == 1 && !waive) begin
                          s_ok = sp > DEPTH / 2; d_ok = f >= DEPTH / 2;
                          tag_s = "R4"; tag_d = "R3";
                      end else begin
                          s_ok = sp >= x; d_ok = f >= x;
                          tag_s = (m == 1) ? "R5" : "R2";
                          tag_d = tag_s;
                      end
                      step();
                      check({tag_s, " src grant"}, src_grant, int'(s_on && s_ok));
                      check({tag_d, " dst grant"}, dst_grant, int'(d_on && d_ok));
                  end
        burst_last = 0; block_last = 0; cfg_half_mode = 0;

        // R1 directed: active-low request lines
        cfg_src_pol = 1; cfg_dst_pol = 1; src_req_in = 0; dst_req_in = 1; fifo_fill = 8;
        step();
        check("R1 active-low src", src_grant, 1);
        check("R1 active-low dst idle", dst_grant, 0);
        cfg_src_pol = 0; cfg_dst_pol = 0;

        // R6: destination controls flow, source held until destination asks
        fifo_fill = 0; xfer_bytes = 1; cfg_src_hold = 1; dst_is_fc = 1;
        block_last = 1; src_req_in = 0; dst_req_in = 0;
        step();
        block_last = 0; src_req_in = 1;
        step();
        check("R6 held before dst", src_grant, 0);
        src_req_in = 0; dst_req_in = 1;
        step();
        dst_req_in = 0; src_req_in = 1;
        step();
        check("R6 released after dst", src_grant, 1);
        step();
        check("R6 release sticky", src_grant, 1);
        block_last = 1;
        step();
        check("R6 block end same cycle", src_grant, 1);
        block_last = 0;
        step();
        check("R6 held after block end", src_grant, 0);
        src_req_in = 1; dst_req_in = 1;
        step();
        check("R6 same-cycle dst", src_grant, 1);
        dst_req_in = 0; ch_en = 0;
        step();
        ch_en = 1;
        step();
        check("R6 cleared by disable", src_grant, 0);

        // R7: no hold when hold bit or flow-controller flag is clear
        dst_is_fc = 0;
        step();
        check("R7 source is flow controller", src_grant, 1);
        dst_is_fc = 1; cfg_src_hold = 0; block_last = 1;
        step();
        block_last = 0;
        step();
        check("R7 hold disabled", src_grant, 1);

        // R8: burst cap sweep
        for (int a = 0; a < 5; a++)
            for (int b = 0; b < 7; b++) begin
                int mx, rq, e;
                mx = (a == 0) ? 0 : (a == 1) ? 1 : (a == 2) ? 5 : (a == 3) ? 512 : 1023;
                rq = (b == 0) ? 0 : (b == 1) ? 1 : (b == 2) ? 4 : (b == 3) ? 5 :
                     (b == 4) ? 6 : (b == 5) ? 600 : 1023;
                cfg_max_burst = 10'(mx); req_burst_len = 10'(rq);
                e = (mx != 0 && rq > mx) ? mx : rq;
                #1;
                check("R8 burst length", int'(burst_len), e);
            end

        // R9: protection attributes
        for (int v = 0; v < 8; v++) begin
            cfg_prot = 3'(v);
            #1;
            check("R9 hprot", int'(hprot), v * 2 + 1);
        end

        // R10: lock gating
        for (int v = 0; v < 4; v++) begin
            cfg_lock = v[0]; lock_want = v[1];
            #1;
            check("R10 bus lock", int'(bus_lock), int'(v == 3));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule